// File: doc/BRIEF.md
# Scan Stepper Phase Sequencer

This block drives the four coil strobes of a scan-carriage stepper motor driver. A step-rate divider turns the system clock into a step cadence. A phase walker then moves through an eight-position excitation wheel. Each position of the wheel energises one coil or two adjacent coils. Full-step operation visits only the two-coil positions, and half-step operation visits all eight.

A two-bit scan-mode input selects both the cadence and the excitation style. Copy mode steps at the slow rate with full steps. Quick and fine modes step at the fast rate with full steps. Super-fine mode steps at the fast rate with half steps. With the defaults and a 19.6608 MHz clock, the slow rate is 49152 cycles per step (400 steps/s) and the fast rate is 32768 cycles per step (600 steps/s).

The direction input picks which way the wheel turns. The run input gates stepping. A mode change is applied only when a step occurs or while the block is idle, so a step period never has its length changed part way through.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst is high and on the first cycle after it falls, phases is 4'b0000 and step_tick is 0. The wheel position starts at the A+B position.
- R2: The mode encoding is 0 = copy (SLOW_DIV cycles per step), 1 = quick, 2 = fine and 3 = super-fine (FAST_DIV cycles per step for modes 1, 2 and 3). Consecutive steps during a continuous run are exactly that many cycles apart.
- R3: phases bit 0 is coil A, bit 1 is B, bit 2 is C and bit 3 is D. In full-step modes 0, 1 and 2, forward steps cycle through 0011, 0110, 1100, 1001, and every step leaves exactly two coils on.
- R4: In mode 3, forward steps cycle through 0011, 0010, 0110, 0100, 1100, 1000, 1001, 0001. A full step taken from a single-coil position moves to the adjacent two-coil position in the walking direction. Every step leaves one or two coils on.
- R5: dir_fwd = 1 walks the sequence forward and dir_fwd = 0 walks it in reverse.
- R6: While run_en is low, no step occurs and phases holds its value. Dropping run_en also restarts the divider, so the first step comes a full period after run_en is raised again.
- R7: The scan mode is sampled only while run_en is low or on the cycle a step happens. A change made in the middle of a period affects neither that period's length nor the kind of step that ends it.
- R8: step_tick is high for exactly one cycle per step, in the same cycle that phases first shows the new pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_mode | input | 2 | Scan mode select (0 copy, 1 quick, 2 fine, 3 super-fine) |
| run_en | input | 1 | Stepping enable |
| dir_fwd | input | 1 | 1 = forward walk, 0 = reverse walk |
| phases | output | 4 | Coil strobes: bit 0 A, bit 1 B, bit 2 C, bit 3 D |
| step_tick | output | 1 | One-cycle pulse marking each step |

## Verification
The sequencer is run for several steps in each of the four modes and in both directions. These runs separate the slow rate from the fast rate, and the two-coil wheel from the eight-position wheel. A reverse half-step run that stops on a single-coil position, followed by a full-step run, checks how the walker returns to the two-coil positions. A short run that is stopped before its first step, followed by a full run, shows whether the divider restarts. Mode changes made partway through a period, in both directions between slow full-step and fast half-step, show whether the new mode takes effect only at the step boundary.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  typedef enum logic [1:0] {
    SM_COPY  = 2'd0,
    SM_QUICK = 2'd1,
    SM_FINE  = 2'd2,
    SM_SUPER = 2'd3
  } scan_mode_e;

  localparam int unsigned NUM_COILS = 4;
  localparam int unsigned POS_W     = 3;
  localparam int unsigned NUM_POS   = 1 << POS_W;

  function automatic logic mode_fast(scan_mode_e m);
    return m != SM_COPY;
  endfunction

  function automatic logic mode_half(scan_mode_e m);
    return m == SM_SUPER;
  endfunction
endpackage

// File: rtl/step_rate_div.sv
module step_rate_div #(
  parameter int unsigned SLOW_DIV = 49152,
  parameter int unsigned FAST_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic step_pulse
);
  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last       = fast ? FAST_LAST : SLOW_LAST;
  assign step_pulse = run && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (step_pulse) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mode_sampler.sv
module mode_sampler
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       step_pulse,
  input  scan_mode_e mode_in,
  output scan_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SM_COPY;
    end else if (!run || step_pulse) begin
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/phase_walker.sv
module phase_walker
  import stepseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 advance,
  input  logic                 half,
  input  logic                 fwd,
  output logic [NUM_COILS-1:0] phases_q,
  output logic                 tick_q
);
  logic [POS_W-1:0]     pos_q;
  logic [POS_W-1:0]     stride;
  logic [POS_W-1:0]     nxt;
  logic [NUM_COILS-1:0] coil_nxt;

  // Single-coil positions are odd, so a full step from one lands on an even position.
  assign stride = (half || pos_q[0]) ? POS_W'(1) : POS_W'(2);
  assign nxt    = fwd ? (pos_q + stride) : (pos_q - stride);

  // Coil k is on for three consecutive positions starting at 2k-2 (mod wheel size).
  for (genvar k = 0; k < NUM_COILS; k++) begin : g_coil
    localparam logic [POS_W-1:0] START = POS_W'((2 * k + NUM_POS - 2) % NUM_POS);
    logic [POS_W-1:0] rel;
    assign rel         = nxt - START;
    assign coil_nxt[k] = (rel <= POS_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      phases_q <= '0;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= advance;
      if (advance) begin
        pos_q    <= nxt;
        phases_q <= coil_nxt;
      end
    end
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepseq_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 49152,
  parameter int unsigned FAST_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] scan_mode,
  input  logic       run_en,
  input  logic       dir_fwd,
  output logic [3:0] phases,
  output logic       step_tick
);
  scan_mode_e mode_in;
  scan_mode_e act_mode;
  logic       step_pulse;
  logic       fast_act;
  logic       half_act;

  assign mode_in  = scan_mode_e'(scan_mode);
  assign fast_act = mode_fast(act_mode);
  assign half_act = mode_half(act_mode);

  step_rate_div #(
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run_en),
    .fast      (fast_act),
    .step_pulse(step_pulse)
  );

  mode_sampler u_mode (
    .clk       (clk),
    .rst       (rst),
    .run       (run_en),
    .step_pulse(step_pulse),
    .mode_in   (mode_in),
    .mode_q    (act_mode)
  );

  phase_walker u_walk (
    .clk     (clk),
    .rst     (rst),
    .advance (step_pulse),
    .half    (half_act),
    .fwd     (dir_fwd),
    .phases_q(phases),
    .tick_q  (step_tick)
  );
endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       run_en,
  input logic [3:0] phases,
  input logic       step_tick,
  input logic       half_act
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step_tick |-> $stable(phases));

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !step_tick);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> !step_tick);

  assert_coils_R4: assert property (@(posedge clk) disable iff (rst)
    step_tick |-> ($countones(phases) == 1 || $countones(phases) == 2));

  assert_full_R3: assert property (@(posedge clk) disable iff (rst)
    (step_tick && !$past(half_act)) |-> ($countones(phases) == 2));
endmodule

bind stepper_phase_seq stepseq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .phases   (phases),
  .step_tick(step_tick),
  .half_act (half_act)
);

// File: tb/stepper_phase_seq_tb_top.sv
`timescale 1ns/1ps
module stepper_phase_seq_tb_top;
  localparam int SLOW = 12;
  localparam int FAST = 8;

  typedef struct {
    logic [3:0] ph;
    int         gap;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] scan_mode = 2'd0;
  logic       run_en = 1'b0;
  logic       dir_fwd = 1'b1;
  logic [3:0] phases;
  logic       step_tick;

  int   total = 0;
  int   bad = 0;
  int   ref_pos = 0;
  int   mcnt = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  stepper_phase_seq #(.SLOW_DIV(SLOW), .FAST_DIV(FAST)) dut_i (
    .clk(clk), .rst(rst), .scan_mode(scan_mode), .run_en(run_en),
    .dir_fwd(dir_fwd), .phases(phases), .step_tick(step_tick)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_pattern(int p);
    case (p)
      0: return 4'b0011;
      1: return 4'b0010;
      2: return 4'b0110;
      3: return 4'b0100;
      4: return 4'b1100;
      5: return 4'b1000;
      6: return 4'b1001;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic push_step(logic [1:0] m, bit d, string req);
    exp_t it;
    int stride;
    stride  = (m == 2'd3 || (ref_pos % 2) == 1) ? 1 : 2;
    ref_pos = d ? (ref_pos + stride) % 8 : (ref_pos + 8 - stride) % 8;
    it.ph   = ref_pattern(ref_pos);
    it.gap  = (m == 2'd0) ? SLOW : FAST;
    it.req  = req;
    exp_q.push_back(it);
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(logic [1:0] m, bit d, int n, string req);
    @(negedge clk);
    scan_mode = m;
    dir_fwd   = d;
    @(negedge clk);
    run_en = 1'b1;
    for (int i = 0; i < n; i++) push_step(m, d, req);
    drain_and_stop();
  endtask

  // Monitor: counts cycles since run start or last step, compares each step with the queue head.
  always begin
    @(posedge clk);
    #1;
    if (rst || !run_en) mcnt = 0;
    else mcnt++;
    if (!rst && step_tick) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected step", int'(phases), 0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(phases == it.ph, it.req, int'(phases), int'(it.ph));
        chk(mcnt == it.gap, "R2 step interval", mcnt, it.gap);
      end
      mcnt = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] snap;
    repeat (4) @(negedge clk);
    chk(phases == 4'b0000 && step_tick == 1'b0, "R1 in reset", int'({step_tick, phases}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(phases == 4'b0000 && step_tick == 1'b0, "R1 after reset", int'({step_tick, phases}), 0);

    run_seq(2'd0, 1'b1, 4, "R3 copy forward");
    run_seq(2'd1, 1'b0, 3, "R5 quick reverse");
    run_seq(2'd2, 1'b1, 2, "R3 fine forward");
    run_seq(2'd3, 1'b1, 9, "R4 superfine forward");
    run_seq(2'd3, 1'b0, 3, "R5 superfine reverse");
    run_seq(2'd0, 1'b1, 2, "R4 snap to two-coil");

    // R6: idle hold
    snap = phases;
    repeat (40) @(negedge clk);
    chk(phases == snap, "R6 hold while idle", int'(phases), int'(snap));

    // R6: partial run shorter than a period, then a full run from a restarted divider
    scan_mode = 2'd1;
    @(negedge clk);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(phases == snap, "R6 no step on short run", int'(phases), int'(snap));
    run_seq(2'd1, 1'b1, 1, "R6 restart after stop");

    // R7: mode changes part way through a period apply at the next boundary
    @(negedge clk);
    scan_mode = 2'd0;
    dir_fwd   = 1'b1;
    @(negedge clk);
    run_en = 1'b1;
    push_step(2'd0, 1'b1, "R7 old mode holds period");
    push_step(2'd3, 1'b1, "R7 new mode after boundary");
    push_step(2'd0, 1'b1, "R7 back to copy");
    repeat (3) @(negedge clk);
    scan_mode = 2'd3;
    while (exp_q.size() > 2) @(negedge clk);
    repeat (2) @(negedge clk);
    scan_mode = 2'd0;
    drain_and_stop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule